// File: doc/BRIEF.md
# Sweep Parameter Register Decoder

This block sits between a serial-to-parallel front end and a frequency sweep engine. Each clock cycle where `word_valid` is high carries one 16-bit control word. The upper bits of the word select a target register, and the lower bits carry its data. The block keeps the whole sweep configuration in registers and presents it to the sweep engine at all times. The configuration is:

- a 24-bit start frequency;
- a 23-bit increment magnitude with a direction flag;
- a 12-bit increment count;
- an 11-bit interval count with a unit-select bit.

The start frequency is written as two 12-bit halves. A paired-write flag in the control register sets how the halves are applied:

- **Paired mode:** a low-half write is parked in a shadow register. The full 24-bit value changes in one step when the next write is the high half.
- **Independent mode:** each half lands directly in the visible register.

All stored outputs change on the clock edge that samples the valid word.

Top module: `sweep_reg_decoder`

## Requirements
- R1: After reset every output is zero: start frequency, increment magnitude, direction, increment count, interval count, interval mode and paired mode.
- R2: A word with bits [15:12] = 0001 loads the increment count from bits [11:0]. Values 0 and 1 are stored as 2.
- R3: A word with bits [15:14] = 01 loads the interval. Bit 13 goes to the interval mode (0 = waveform cycles, 1 = clock periods). Bits [10:0] go to the interval count, with values 0 and 1 stored as 2. Bits [12:11] have no effect.
- R4: A word with bits [15:12] = 0010 loads increment bits [11:0] from bits [11:0]. The upper increment bits are kept.
- R5: A word with bits [15:12] = 0011 loads increment bits [22:12] from bits [10:0] and the direction flag from bit 11 (0 = add, 1 = subtract). The lower increment bits are kept.
- R6: A word with bits [15:12] = 0000 sets paired mode from bit 11.
- R7: In independent mode, bits [15:12] = 1100 write start bits [11:0], and 1101 write start bits [23:12]. Each write leaves the other half unchanged.
- R8: In paired mode, a 1100 write leaves the visible start frequency unchanged. If the very next valid word is a 1101 write, the start frequency becomes {high data, held low data} in one step.
- R9: In paired mode, any valid word other than 1100 or 1101 that arrives between the two halves discards the held low half. A 1101 write with no held low half updates only bits [23:12].
- R10: Words with bits [15:12] in 1000–1011, 1110 or 1111 change no output. Cycles with `word_valid` low change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Marks the cycle carrying a control word |
| word_data | input | 16 | Control word: address in upper bits, data in lower bits |
| start_freq | output | 24 | Visible start frequency |
| incr_mag | output | 23 | Increment magnitude |
| incr_dir | output | 1 | Sweep direction, 1 = subtract |
| incr_count | output | 12 | Number of increments |
| interval_count | output | 11 | Interval length |
| interval_mode | output | 1 | Interval unit, 1 = clock periods |
| paired_mode | output | 1 | Start-word paired-write flag |

## Verification
The bench sweeps every increment count value and every interval count value. This catches a clamp that is off by one: such a design would store 1, or would raise 2 or 3 as well. The interval sweep also varies the two unused bits and the whole 01xx address range, so decoding only 0100 would be caught.

The paired-mode sequences target two faults. One is a visible low half that leaks out early. The other is a held half that survives an intervening write and later appears in the start word. Unmapped addresses and idle cycles carrying garbage data are checked for any change on every output.

// File: rtl/swp_pkg.sv
package swp_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_COUNT,
    SEL_INC_LO,
    SEL_INC_HI,
    SEL_INTERVAL,
    SEL_START_LO,
    SEL_START_HI
  } reg_sel_e;

  // Raise values 0 and 1 to the legal minimum of 2.
  function automatic logic [15:0] floor_at_two(input logic [15:0] v);
    return (v < 16'd2) ? 16'd2 : v;
  endfunction

endpackage

// File: rtl/swp_addr_decode.sv
module swp_addr_decode
  import swp_pkg::*;
(
  input  logic       valid,
  input  logic [3:0] nibble,
  output reg_sel_e   sel
);
  always_comb begin
    sel = SEL_NONE;
    if (valid) begin
      if (nibble[3:2] == 2'b01) begin
        sel = SEL_INTERVAL;
      end else begin
        case (nibble)
          4'b0000: sel = SEL_CTRL;
          4'b0001: sel = SEL_COUNT;
          4'b0010: sel = SEL_INC_LO;
          4'b0011: sel = SEL_INC_HI;
          4'b1100: sel = SEL_START_LO;
          4'b1101: sel = SEL_START_HI;
          default: sel = SEL_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/swp_start_reg.sv
module swp_start_reg #(
  parameter int HALF_W = 12,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_other,
  input  logic              paired,
  input  logic [HALF_W-1:0] half_data,
  output logic [FULL_W-1:0] start_q,
  output logic              pending,
  output logic              commit_fire
);
  logic [HALF_W-1:0] shadow_q;

  assign commit_fire = wr_hi && paired && pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= '0;
      shadow_q <= '0;
      pending  <= 1'b0;
    end else if (wr_lo) begin
      if (paired) begin
        shadow_q <= half_data;
        pending  <= 1'b1;
      end else begin
        start_q[HALF_W-1:0] <= half_data;
        pending             <= 1'b0;
      end
    end else if (wr_hi) begin
      if (commit_fire) begin
        start_q <= {half_data, shadow_q};
      end else begin
        start_q[FULL_W-1:HALF_W] <= half_data;
      end
      pending <= 1'b0;
    end else if (wr_other) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/swp_field_regs.sv
module swp_field_regs
  import swp_pkg::*;
#(
  parameter int HALF_W = 12,
  parameter int INC_W  = 23,
  parameter int CNT_W  = 12,
  parameter int INT_W  = 11,
  localparam int INC_HI_W = INC_W - HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          sel,
  input  logic [15:0]       data,
  output logic [INC_W-1:0]  incr_mag,
  output logic              incr_dir,
  output logic [CNT_W-1:0]  incr_count,
  output logic [INT_W-1:0]  interval_count,
  output logic              interval_mode,
  output logic              paired_mode
);
  logic [15:0] count_floor;
  logic [15:0] interval_floor;

  assign count_floor    = floor_at_two(16'(data[CNT_W-1:0]));
  assign interval_floor = floor_at_two(16'(data[INT_W-1:0]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      incr_mag       <= '0;
      incr_dir       <= 1'b0;
      incr_count     <= '0;
      interval_count <= '0;
      interval_mode  <= 1'b0;
      paired_mode    <= 1'b0;
    end else begin
      case (sel)
        SEL_CTRL:     paired_mode <= data[11];
        SEL_COUNT:    incr_count  <= count_floor[CNT_W-1:0];
        SEL_INC_LO:   incr_mag[HALF_W-1:0] <= data[HALF_W-1:0];
        SEL_INC_HI: begin
          incr_mag[INC_W-1:HALF_W] <= data[INC_HI_W-1:0];
          incr_dir                 <= data[11];
        end
        SEL_INTERVAL: begin
          interval_count <= interval_floor[INT_W-1:0];
          interval_mode  <= data[13];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sweep_reg_decoder.sv
module sweep_reg_decoder
  import swp_pkg::*;
#(
  parameter int HALF_W = 12,
  parameter int INC_W  = 23,
  parameter int CNT_W  = 12,
  parameter int INT_W  = 11,
  localparam int START_W = 2 * HALF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_valid,
  input  logic [15:0]        word_data,
  output logic [START_W-1:0] start_freq,
  output logic [INC_W-1:0]   incr_mag,
  output logic               incr_dir,
  output logic [CNT_W-1:0]   incr_count,
  output logic [INT_W-1:0]   interval_count,
  output logic               interval_mode,
  output logic               paired_mode
);
  reg_sel_e sel;
  logic     wr_start_lo;
  logic     wr_start_hi;
  logic     wr_other;
  logic     start_pending;
  logic     commit_fire;

  swp_addr_decode u_dec (
    .valid  (word_valid),
    .nibble (word_data[15:12]),
    .sel    (sel)
  );

  assign wr_start_lo = (sel == SEL_START_LO);
  assign wr_start_hi = (sel == SEL_START_HI);
  assign wr_other    = word_valid && !wr_start_lo && !wr_start_hi;

  swp_start_reg #(.HALF_W(HALF_W)) u_start (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_lo       (wr_start_lo),
    .wr_hi       (wr_start_hi),
    .wr_other    (wr_other),
    .paired      (paired_mode),
    .half_data   (word_data[HALF_W-1:0]),
    .start_q     (start_freq),
    .pending     (start_pending),
    .commit_fire (commit_fire)
  );

  swp_field_regs #(
    .HALF_W(HALF_W), .INC_W(INC_W), .CNT_W(CNT_W), .INT_W(INT_W)
  ) u_fields (
    .clk            (clk),
    .rst_n          (rst_n),
    .sel            (sel),
    .data           (word_data),
    .incr_mag       (incr_mag),
    .incr_dir       (incr_dir),
    .incr_count     (incr_count),
    .interval_count (interval_count),
    .interval_mode  (interval_mode),
    .paired_mode    (paired_mode)
  );
endmodule

// File: rtl/swp_checker.sv
module swp_checker #(
  parameter int HALF_W = 12,
  parameter int INC_W  = 23,
  parameter int CNT_W  = 12,
  parameter int INT_W  = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                word_valid,
  input logic [15:0]         word_data,
  input logic [2*HALF_W-1:0] start_freq,
  input logic [INC_W-1:0]    incr_mag,
  input logic                incr_dir,
  input logic [CNT_W-1:0]    incr_count,
  input logic [INT_W-1:0]    interval_count,
  input logic                interval_mode,
  input logic                paired_mode,
  input logic                start_pending,
  input logic                commit_fire
);
  logic lo_word;
  logic hi_word;
  assign lo_word = word_valid && (word_data[15:12] == 4'b1100);
  assign hi_word = word_valid && (word_data[15:12] == 4'b1101);

  AST_COUNT_NEVER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    incr_count != CNT_W'(1)); // R2

  AST_INTERVAL_NEVER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    interval_count != INT_W'(1)); // R3

  AST_DIR_FOLLOWS_BIT11: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_data[15:12] == 4'b0011) |=> (incr_dir == $past(word_data[11]))); // R5

  AST_DIRECT_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_word && !paired_mode) |=> (start_freq[HALF_W-1:0] == $past(word_data[HALF_W-1:0]))); // R7

  AST_PAIRED_LOW_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_word && paired_mode) |=> $stable(start_freq)); // R8

  AST_COMMIT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> (start_pending && paired_mode && hi_word)); // R8

  AST_OTHER_DROPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !lo_word) |=> !start_pending); // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> $stable({start_freq, incr_mag, incr_dir, incr_count,
                             interval_count, interval_mode, paired_mode})); // R10
endmodule

bind sweep_reg_decoder swp_checker #(
  .HALF_W(HALF_W), .INC_W(INC_W), .CNT_W(CNT_W), .INT_W(INT_W)
) u_swp_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .word_valid     (word_valid),
  .word_data      (word_data),
  .start_freq     (start_freq),
  .incr_mag       (incr_mag),
  .incr_dir       (incr_dir),
  .incr_count     (incr_count),
  .interval_count (interval_count),
  .interval_mode  (interval_mode),
  .paired_mode    (paired_mode),
  .start_pending  (start_pending),
  .commit_fire    (commit_fire)
);

// File: tb/sweep_reg_decoder_tb_top.sv
`timescale 1ns/1ps
module sweep_reg_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = 16'h0;
  logic [23:0] start_freq;
  logic [22:0] incr_mag;
  logic        incr_dir;
  logic [11:0] incr_count;
  logic [10:0] interval_count;
  logic        interval_mode;
  logic        paired_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state, kept in plain integers
  int m_start, m_inc, m_dir, m_cnt, m_int, m_mode, m_pair, m_shadow, m_pend;

  always #4 clk = ~clk;

  sweep_reg_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .start_freq(start_freq), .incr_mag(incr_mag), .incr_dir(incr_dir),
    .incr_count(incr_count), .interval_count(interval_count),
    .interval_mode(interval_mode), .paired_mode(paired_mode)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "start_freq", int'(start_freq), m_start);
    chk(tag, "incr_mag", int'(incr_mag), m_inc);
    chk(tag, "incr_dir", int'(incr_dir), m_dir);
    chk(tag, "incr_count", int'(incr_count), m_cnt);
    chk(tag, "interval_count", int'(interval_count), m_int);
    chk(tag, "interval_mode", int'(interval_mode), m_mode);
    chk(tag, "paired_mode", int'(paired_mode), m_pair);
  endtask

  task automatic model(input int w);
    int op, d12;
    op  = w / 4096;
    d12 = w % 4096;
    if (op >= 4 && op <= 7) begin
      m_int  = ((w % 2048) < 2) ? 2 : (w % 2048);
      m_mode = (w / 8192) % 2;
      m_pend = 0;
    end else if (op == 0) begin
      m_pair = (w / 2048) % 2; m_pend = 0;
    end else if (op == 1) begin
      m_cnt = (d12 < 2) ? 2 : d12; m_pend = 0;
    end else if (op == 2) begin
      m_inc = (m_inc / 4096) * 4096 + d12; m_pend = 0;
    end else if (op == 3) begin
      m_inc = (m_inc % 4096) + (w % 2048) * 4096;
      m_dir = (w / 2048) % 2; m_pend = 0;
    end else if (op == 12) begin
      if (m_pair != 0) begin m_shadow = d12; m_pend = 1; end
      else begin m_start = (m_start / 4096) * 4096 + d12; m_pend = 0; end
    end else if (op == 13) begin
      if (m_pair != 0 && m_pend != 0) m_start = d12 * 4096 + m_shadow;
      else m_start = d12 * 4096 + (m_start % 4096);
      m_pend = 0;
    end else begin
      m_pend = 0;
    end
  endtask

  task automatic wr(input int w, input string tag);
    @(negedge clk);
    word_valid = 1'b1;
    word_data  = 16'(w);
    model(w);
    @(negedge clk);
    word_valid = 1'b0;
    word_data  = 16'hA5A5;
    check_all(tag);
  endtask

  initial begin
    m_start = 0; m_inc = 0; m_dir = 0; m_cnt = 0; m_int = 0;
    m_mode = 0; m_pair = 0; m_shadow = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    wr(16'h0800, "R6");
    wr(16'h0000, "R6");

    // independent halves
    wr(16'hCABC, "R7");
    wr(16'hD123, "R7");
    wr(16'hC777, "R7");
    wr(16'hDFED, "R7");

    for (int v = 0; v < 4096; v++) wr(16'h1000 + v, "R2");

    for (int v = 0; v < 2048; v++)
      wr(16'h4000 + (v % 2) * 8192 + ((v / 2) % 4) * 2048 + v, "R3");

    for (int i = 0; i < 64; i++) begin
      wr(16'h2000 + (i * 67) % 4096, "R4");
      wr(16'h3000 + (i % 2) * 2048 + (i * 331) % 2048, "R5");
    end

    // paired writes
    wr(16'h0800, "R6");
    wr(16'hC111, "R8");
    wr(16'hD222, "R8");
    wr(16'hCF0F, "R8");
    wr(16'hC0F0, "R8");
    wr(16'hD5A5, "R8");
    wr(16'hC333, "R9");
    wr(16'h1005, "R9");
    wr(16'hD444, "R9");
    wr(16'hC999, "R9");
    wr(16'h8000, "R9");
    wr(16'hD666, "R9");
    wr(16'hC555, "R9");
    wr(16'h0000, "R9");
    wr(16'hDBBB, "R9");

    // unmapped addresses and idle cycles
    for (int op = 8; op < 16; op++)
      if (op != 12 && op != 13) wr(op * 4096 + 16'h0FFF, "R10");
    @(negedge clk);
    word_data = 16'hFFFF;
    repeat (4) @(negedge clk);
    word_data = 16'hC123;
    repeat (4) @(negedge clk);
    check_all("R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule